// File: doc/BRIEF.md
# Prioritised Ternary Multicast Route Matcher

The block takes the 32-bit key of a multicast packet and compares it with every entry of a small table at the same time. Each entry stores a key word and a mask word. Together they give each bit position one of four behaviours: always match, never match, match a 0, or match a 1. An entry hits only when every bit position matches. When several entries hit, the one with the lowest index wins. A specific entry placed at a low index can therefore carve a single key or a sub-range out of a wider entry further down the table. The winning entry selects a 24-bit route word, and each set bit in that word asks for a copy of the packet on that output.

Lookups use a valid/ready handshake. A request carries the key and the number of the link it arrived on. The result comes back exactly two cycles later, in request order, together with a hit flag. When no entry hits, a packet that came in on an off-chip link (0 to 5) is sent out on the link opposite its arrival link. A packet from an internal source (link 6 or 7) gets an empty route and a drop flag instead.

A configuration write port loads table key words, mask words, route words and a test key. A key or mask write takes two cycles, and lookups are held off during those two cycles. Table contents cannot be read back. Instead, the test key is matched against the table, and the block reports whether it hits and which entry is the first to match.

Top module: `mrm_route_matcher`

## Requirements
- R1: For each bit position, the stored pair (mask bit, key bit) behaves as follows: (0,0) always matches, (0,1) never matches, (1,0) matches an incoming 0, and (1,1) matches an incoming 1.
- R2: An entry hits only when all 32 of its bit positions match. An entry with any (0,1) bit position never hits. After reset every entry holds mask 0 and key all-ones, so every entry is disabled.
- R3: When more than one entry hits, the lowest-indexed entry is used.
- R4: On a hit, rsp_hit is 1, rsp_drop is 0, and rsp_route equals the route word of the winning entry.
- R5: On a miss from arrival link i in 0..5, rsp_hit is 0, rsp_drop is 0, and rsp_route has only bit ((i+3) mod 6) set.
- R6: On a miss from arrival link 6 or 7, rsp_route is all zeros and rsp_drop is 1.
- R7: A request accepted in cycle c (req_valid and req_ready both high at the closing edge) produces rsp_valid high for exactly one cycle, in cycle c+2. Back-to-back requests return in order on consecutive cycles.
- R8: cfg_sel encodes the write target: 0 writes a table key word, 1 writes a table mask word, 2 writes a route word (low 24 bits of cfg_data), 3 writes the test key. A key or mask write holds req_ready low in the cycle the write is presented and in the following cycle. The new value applies to lookups accepted after that.
- R9: In the cycle after a test-key write, test_hit shows whether the test key hits any entry, and test_idx shows the lowest matching index. test_idx is 0 when there is no hit.
- R10: Out of reset, rsp_valid is 0, req_ready is 1 and test_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_key | input | 32 | Packet key to match |
| req_link | input | 3 | Arrival link; 0-5 off-chip, 6-7 internal |
| rsp_valid | output | 1 | Lookup result present |
| rsp_route | output | 24 | Output-link vector |
| rsp_hit | output | 1 | A table entry matched |
| rsp_drop | output | 1 | Internal-source miss; packet should be dropped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 key, 1 mask, 2 route, 3 test key |
| cfg_idx | input | 4 | Table entry index |
| cfg_data | input | 32 | Write data |
| test_hit | output | 1 | Test key hits an entry |
| test_idx | output | 4 | First entry matching the test key |

## Verification
The assertions check on every cycle that responses appear exactly two cycles after each accepted request and at no other time. They also check that every miss from an off-chip link yields exactly one route bit, that a drop always comes with an empty route and no hit, that key and mask writes stall the request side for both cycles, and that test_idx is 0 when there is no test hit. Only the bench's scenarios can show the actual ternary matching: the meaning of each bit code, the shadowing of a wider entry by a lower-indexed exact entry, that a never-match bit disables an entry, the link-opposite default values, and that a rewritten entry takes effect.

// File: rtl/mrm_pkg.sv
// Package: shared encodings for the multicast route matcher.
// Assumes a 2-bit configuration target select.
package mrm_pkg;
    typedef enum logic [1:0] {
        CFG_KEY   = 2'd0,
        CFG_MASK  = 2'd1,
        CFG_ROUTE = 2'd2,
        CFG_TEST  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/mrm_entry_store.sv
// Module: mrm_entry_store
// Holds the ternary key and mask words of every table entry. A write is
// captured into a pending register in its first cycle and committed in
// the second; busy marks the commit cycle. A new write arriving during a
// commit is captured while the older one commits.
// Assumes: reset leaves every entry disabled (mask 0, key all-ones).
module mrm_entry_store #(
    parameter int KEY_W = 32,
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_is_mask,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [KEY_W-1:0]              wr_data,
    output logic [N_ENT-1:0][KEY_W-1:0]   key_tab,
    output logic [N_ENT-1:0][KEY_W-1:0]   mask_tab,
    output logic                          busy
);
    logic             pend_valid;
    logic             pend_is_mask;
    logic [IDX_W-1:0] pend_idx;
    logic [KEY_W-1:0] pend_data;

    // Capture stage of the two-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid   <= 1'b0;
            pend_is_mask <= 1'b0;
            pend_idx     <= '0;
            pend_data    <= '0;
        end else begin
            pend_valid <= wr_en;
            if (wr_en) begin
                pend_is_mask <= wr_is_mask;
                pend_idx     <= wr_idx;
                pend_data    <= wr_data;
            end
        end
    end

    // Commit stage: one storage row per entry.
    for (genvar e = 0; e < N_ENT; e++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_tab[e]  <= '1;
                mask_tab[e] <= '0;
            end else if (pend_valid && pend_idx == IDX_W'(e)) begin
                if (pend_is_mask) mask_tab[e] <= pend_data;
                else              key_tab[e]  <= pend_data;
            end
        end
    end

    assign busy = pend_valid;
endmodule

// File: rtl/mrm_ternary_match.sv
// Module: mrm_ternary_match
// Compares one key against every entry in parallel. Per bit, a set mask
// bit compares with the stored key bit; a clear mask bit matches always
// when the stored key bit is 0 and never when it is 1.
// Assumes: purely combinational; caller registers around it.
module mrm_ternary_match #(
    parameter int KEY_W = 32,
    parameter int N_ENT = 16
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [N_ENT-1:0][KEY_W-1:0]   key_tab,
    input  logic [N_ENT-1:0][KEY_W-1:0]   mask_tab,
    output logic [N_ENT-1:0]              hits
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [KEY_W-1:0] bit_ok;
        // Per-bit match terms followed by the AND across the word.
        always_comb begin
            bit_ok  = (mask_tab[e] & ~(key_tab[e] ^ key)) | (~mask_tab[e] & ~key_tab[e]);
            hits[e] = &bit_ok;
        end
    end
endmodule

// File: rtl/mrm_prio_enc.sv
// Module: mrm_prio_enc
// Finds the lowest-indexed set bit of a hit vector (index 0 wins).
// Assumes: idx is 0 when no bit is set.
module mrm_prio_enc #(
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_ENT-1:0] hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest priority upward so the highest priority wins last.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (hits[e]) idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/mrm_route_matcher.sv
// Module: mrm_route_matcher (top)
// Two-stage multicast lookup: stage 1 registers the request, stage 2
// registers the entry hit vector, and the output selects the winning
// route word or the arrival-link default. Key and mask writes stall
// request acceptance for two cycles; a test key is matched continuously.
// Assumes: links 0..N_LINKS-1 are off-chip, higher codes are internal.
module mrm_route_matcher
    import mrm_pkg::*;
#(
    parameter int KEY_W   = 32,
    parameter int N_ENT   = 16,
    parameter int ROUTE_W = 24,
    parameter int N_LINKS = 6,
    parameter int LINK_W  = 3,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [KEY_W-1:0]   req_key,
    input  logic [LINK_W-1:0]  req_link,
    output logic               rsp_valid,
    output logic [ROUTE_W-1:0] rsp_route,
    output logic               rsp_hit,
    output logic               rsp_drop,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [KEY_W-1:0]   cfg_data,
    output logic               test_hit,
    output logic [IDX_W-1:0]   test_idx
);
    localparam int OPP_W = LINK_W + 1;

    logic                            tab_we;
    logic                            store_busy;
    logic [N_ENT-1:0][KEY_W-1:0]     key_tab;
    logic [N_ENT-1:0][KEY_W-1:0]     mask_tab;
    logic [N_ENT-1:0][ROUTE_W-1:0]   route_tab;
    logic [KEY_W-1:0]                test_key;
    logic                            accept;

    logic                s1_valid;
    logic [KEY_W-1:0]    s1_key;
    logic [LINK_W-1:0]   s1_link;
    logic [N_ENT-1:0]    s1_hits;

    logic                s2_valid;
    logic [N_ENT-1:0]    s2_hits;
    logic [LINK_W-1:0]   s2_link;
    logic                s2_any;
    logic [IDX_W-1:0]    s2_idx;

    logic [N_ENT-1:0]    test_hits;
    logic [OPP_W-1:0]    opp_link;
    logic [ROUTE_W-1:0]  dflt_route;
    logic                from_internal;

    // Table write decode and request-side stall.
    always_comb begin
        tab_we    = cfg_we && (cfg_sel == CFG_KEY || cfg_sel == CFG_MASK);
        req_ready = !tab_we && !store_busy;
        accept    = req_valid && req_ready;
    end

    mrm_entry_store #(.KEY_W(KEY_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tab_we),
        .wr_is_mask (cfg_sel == CFG_MASK),
        .wr_idx     (cfg_idx),
        .wr_data    (cfg_data),
        .key_tab    (key_tab),
        .mask_tab   (mask_tab),
        .busy       (store_busy)
    );

    // Route words: single-cycle write, one row per entry.
    for (genvar e = 0; e < N_ENT; e++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n) route_tab[e] <= '0;
            else if (cfg_we && cfg_sel == CFG_ROUTE && cfg_idx == IDX_W'(e))
                route_tab[e] <= cfg_data[ROUTE_W-1:0];
        end
    end

    // Test key register.
    always_ff @(posedge clk) begin
        if (!rst_n) test_key <= '0;
        else if (cfg_we && cfg_sel == CFG_TEST) test_key <= cfg_data;
    end

    // Stage 1: capture accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_key   <= '0;
            s1_link  <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_key  <= req_key;
                s1_link <= req_link;
            end
        end
    end

    mrm_ternary_match #(.KEY_W(KEY_W), .N_ENT(N_ENT)) u_lookup_match (
        .key      (s1_key),
        .key_tab  (key_tab),
        .mask_tab (mask_tab),
        .hits     (s1_hits)
    );

    // Stage 2: capture hit vector and arrival link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_hits  <= '0;
            s2_link  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_hits <= s1_hits;
                s2_link <= s1_link;
            end
        end
    end

    mrm_prio_enc #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_lookup_prio (
        .hits (s2_hits),
        .any  (s2_any),
        .idx  (s2_idx)
    );

    // Default route: the link opposite the arrival link, or none if internal.
    always_comb begin
        from_internal = s2_link >= LINK_W'(N_LINKS);
        opp_link      = {1'b0, s2_link} + OPP_W'(N_LINKS / 2);
        if (opp_link >= OPP_W'(N_LINKS)) opp_link = opp_link - OPP_W'(N_LINKS);
        dflt_route    = from_internal ? '0 : (ROUTE_W'(1) << opp_link);
    end

    // Response outputs.
    always_comb begin
        rsp_valid = s2_valid;
        rsp_hit   = s2_valid && s2_any;
        rsp_drop  = s2_valid && !s2_any && from_internal;
        if (!s2_valid)   rsp_route = '0;
        else if (s2_any) rsp_route = route_tab[s2_idx];
        else             rsp_route = dflt_route;
    end

    mrm_ternary_match #(.KEY_W(KEY_W), .N_ENT(N_ENT)) u_test_match (
        .key      (test_key),
        .key_tab  (key_tab),
        .mask_tab (mask_tab),
        .hits     (test_hits)
    );

    mrm_prio_enc #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_test_prio (
        .hits (test_hits),
        .any  (test_hit),
        .idx  (test_idx)
    );
endmodule

// File: rtl/mrm_route_matcher_checker.sv
// Module: mrm_route_matcher_checker
// Port-level properties of the route matcher, bound to every instance.
module mrm_route_matcher_checker #(
    parameter int ROUTE_W = 24,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [ROUTE_W-1:0] rsp_route,
    input logic               rsp_hit,
    input logic               rsp_drop,
    input logic               cfg_we,
    input logic [1:0]         cfg_sel,
    input logic               test_hit,
    input logic [IDX_W-1:0]   test_idx
);
    logic tab_write;
    assign tab_write = cfg_we && (cfg_sel == 2'd0 || cfg_sel == 2'd1);

    // R7: a response two cycles after each accepted request.
    assert_rsp_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready, 2) |-> rsp_valid);
    // R7: no response without a request two cycles earlier.
    assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready, 2));
    // R5: an off-chip miss routes to exactly one link.
    assert_default_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_drop) |-> ($countones(rsp_route) == 1));
    // R6: a drop carries an empty route and no hit.
    assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_drop |-> (rsp_valid && !rsp_hit && rsp_route == '0));
    // R4: a hit is never a drop.
    assert_hit_not_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && !rsp_drop));
    // R8: stall in the write cycle.
    assert_stall_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tab_write |-> !req_ready);
    // R8: stall in the cycle after the write.
    assert_stall_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tab_write |=> !req_ready);
    // R9: index reads 0 when the test key misses.
    assert_test_idx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_hit |-> (test_idx == '0));
endmodule

bind mrm_route_matcher mrm_route_matcher_checker #(
    .ROUTE_W (ROUTE_W),
    .IDX_W   (IDX_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_route (rsp_route),
    .rsp_hit   (rsp_hit),
    .rsp_drop  (rsp_drop),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .test_hit  (test_hit),
    .test_idx  (test_idx)
);

// File: tb/mrm_route_matcher_bench.sv
// Bench for mrm_route_matcher: vector table walk plus directed tests.
module mrm_route_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_key = '0;
    logic [2:0]  req_link = '0;
    logic        rsp_valid;
    logic [23:0] rsp_route;
    logic        rsp_hit;
    logic        rsp_drop;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        test_hit;
    logic [3:0]  test_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mrm_route_matcher u_mrm_route_matcher (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_key(req_key), .req_link(req_link),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_hit(rsp_hit), .rsp_drop(rsp_drop),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .test_hit(test_hit), .test_idx(test_idx)
    );

    typedef struct packed {
        logic [31:0] key;
        logic [2:0]  link;
        logic        hit;
        logic [23:0] route;
        logic        drop;
        logic [3:0]  req;
    } vec_t;

    // Expected results for the programmed table (see program_table).
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h5A5A5A5A, 3'd0, 1'b1, 24'h000001, 1'b0, 4'd3},
        '{32'h5A5A5A5B, 3'd0, 1'b1, 24'h000002, 1'b0, 4'd1},
        '{32'h5A5A5AFF, 3'd2, 1'b1, 24'h000002, 1'b0, 4'd4},
        '{32'h5A5A5B00, 3'd1, 1'b0, 24'h000010, 1'b0, 4'd5},
        '{32'h80000000, 3'd3, 1'b1, 24'hF00000, 1'b0, 4'd4},
        '{32'hDA5A5A5A, 3'd0, 1'b1, 24'hF00000, 1'b0, 4'd3},
        '{32'h12340000, 3'd5, 1'b0, 24'h000004, 1'b0, 4'd2},
        '{32'h12340001, 3'd4, 1'b0, 24'h000002, 1'b0, 4'd2},
        '{32'h00000013, 3'd0, 1'b1, 24'h800000, 1'b0, 4'd1},
        '{32'h00000113, 3'd6, 1'b0, 24'h000000, 1'b1, 4'd6},
        '{32'h7FFFFFFF, 3'd7, 1'b0, 24'h000000, 1'b1, 4'd6},
        '{32'h00000010, 3'd7, 1'b1, 24'h800000, 1'b0, 4'd1},
        '{32'h00000001, 3'd3, 1'b0, 24'h000001, 1'b0, 4'd5}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_entry(input logic [3:0] idx, input logic [31:0] k, input logic [31:0] m, input logic [23:0] r);
        cfg_write(2'd0, idx, k);
        cfg_write(2'd1, idx, m);
        cfg_write(2'd2, idx, {8'h00, r});
    endtask

    task automatic program_table();
        program_entry(4'd0, 32'h5A5A5A5A, 32'hFFFFFFFF, 24'h000001); // exact key
        program_entry(4'd1, 32'h5A5A5A00, 32'hFFFFFF00, 24'h000002); // range of 256
        program_entry(4'd2, 32'h80000000, 32'h80000000, 24'hF00000); // top bit set
        program_entry(4'd3, 32'h12340001, 32'hFFFF0000, 24'h0000FF); // bit0 never-match
        program_entry(4'd5, 32'h00000010, 32'h0000FFF0, 24'h800000); // bits 15:4 == 0x001
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] k, input logic [2:0] l,
                          input logic eh, input logic [23:0] er, input logic ed, input string req);
        req_valid = 1'b1; req_key = k; req_link = l;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "rsp_valid one cycle after accept", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R7", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, eh});
        chk(req, "rsp_route", {8'd0, rsp_route}, {8'd0, er});
        chk(req, "rsp_drop", {31'd0, rsp_drop}, {31'd0, ed});
        @(negedge clk);
        chk("R7", "rsp_valid single cycle", {31'd0, rsp_valid}, 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        chk("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R10", "test_hit", {31'd0, test_hit}, 32'd0);
        // R2: reset entries disabled, lookup misses and takes default.
        lookup(32'h00000000, 3'd0, 1'b0, 24'h000008, 1'b0, "R2");
        cfg_write(2'd3, 4'd0, 32'hFFFFFFFF);
        chk("R2", "test_hit after reset", {31'd0, test_hit}, 32'd0);

        program_table();

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            lookup(VECS[v].key, VECS[v].link, VECS[v].hit, VECS[v].route, VECS[v].drop,
                   $sformatf("R%0d", VECS[v].req));
        end

        // R7: back-to-back requests return in order.
        req_valid = 1'b1; req_key = 32'h5A5A5A5A; req_link = 3'd0;
        @(negedge clk);
        req_key = 32'h12340000; req_link = 3'd1;
        @(negedge clk);
        req_key = 32'h00000113; req_link = 3'd6;
        chk("R7", "first in order", {8'd0, rsp_route}, 32'h000001);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "second in order", {8'd0, rsp_route}, 32'h000010);
        @(negedge clk);
        chk("R7", "third in order drop", {31'd0, rsp_drop}, 32'd1);
        @(negedge clk);
        chk("R7", "pipeline drained", {31'd0, rsp_valid}, 32'd0);

        // R9: test key reports first match.
        cfg_write(2'd3, 4'd0, 32'h5A5A5A5A);
        chk("R9", "test_hit exact", {31'd0, test_hit}, 32'd1);
        chk("R9", "test_idx exact", {28'd0, test_idx}, 32'd0);
        cfg_write(2'd3, 4'd0, 32'h5A5A5A77);
        chk("R9", "test_idx range", {28'd0, test_idx}, 32'd1);
        cfg_write(2'd3, 4'd0, 32'h12340001);
        chk("R9", "test_hit disabled entry", {31'd0, test_hit}, 32'd0);
        chk("R9", "test_idx miss", {28'd0, test_idx}, 32'd0);

        // R8: key write stalls for two cycles, then takes effect.
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_idx = 4'd0; cfg_data = 32'h00000000;
        #1;
        chk("R8", "ready in write cycle", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8", "ready in second cycle", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R8", "ready after write", {31'd0, req_ready}, 32'd1);
        cfg_write(2'd0, 4'd0, 32'h00000000);
        @(negedge clk);
        // R1: entry 0 now (0,0) everywhere: always matches.
        lookup(32'h12340001, 3'd4, 1'b1, 24'h000001, 1'b0, "R1");
        lookup(32'hFFFFFFFF, 3'd6, 1'b1, 24'h000001, 1'b0, "R3");
        // R8: route word write needs no stall.
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_idx = 4'd0; cfg_data = 32'h00ABCDEF;
        #1;
        chk("R8", "route write no stall", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        lookup(32'h00000000, 3'd2, 1'b1, 24'hABCDEF, 1'b0, "R4");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule